// File: doc/BRIEF.md
# Pseudo-SRAM Sleep and Retention Controller

This block is the device-side power sequencer of a pseudo-SRAM. It watches the chip select, write enable, the two byte-lane enables, the active-low sleep strobe (`zz_n`) and the five lowest address bits. While the sleep strobe is high, it reports whether the device idles or serves an access. When the sleep strobe falls, it opens a short programming window. An ordinary write cycle made inside that window loads a pending mode word from the address bits, and the data bus plays no part. The pending word becomes the working setting on the next rise of the sleep strobe. If the window closes with no write, the device enters the low-power state that the working setting selects. That state either refreshes the whole array, refreshes one half or one quarter of it, or drops all contents.

The controller drives four things: a refresh enable, the inclusive address window that refresh has to cover, a four-bit mask of the array quarters whose contents survived the last low-power period, and a busy flag. Busy is high during the power-up wait and during the recovery that follows a deep power-down. All timing is counted in clock cycles derived from `CLK_PER_US`. A build option selects a direct variant, in which every fall of the sleep strobe goes straight to deep power-down and the mode word is never loaded. The memory array itself is not part of this block.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: Reset puts `busy_o`=1, `mode_o`=0 (power-up wait), `refresh_en_o`=0 and `valid_mask_o`=0000. After `PWRUP_US` microseconds, busy drops, `mode_o` becomes 1 (standby) and the mask becomes 1111.
- R2: With `zz_n` high and not busy, `mode_o` is 2 (active) when `cs_n` is low and at least one of `lb_n`/`ub_n` is low. Otherwise it is 1 (standby). The mode codes are 0 power-up, 1 standby, 2 active, 3 programming window, 4 mode write seen, 5 retaining sleep, 6 deep power-down, 7 recovery.
- R3: While busy, all access strobes and `zz_n` are ignored, and `mode_o` stays 0 or 7.
- R4: A write cycle (`cs_n`=0, `we_n`=0, a byte lane low) that starts within `ZZWE_US` of the fall of `zz_n` gives `mode_o`=4 and loads `addr_lo` into a pending word. That word takes effect on the next rise of `zz_n`.
- R5: If no write starts inside the window, the controller enters mode 5, or mode 6 when bit 4 of the working word is 0. Writes made after the window has closed are ignored.
- R6: Bit 3 of the word selects the mode: 0 is partial refresh, 1 is reduced size. Bit 2 selects the half: 0 bottom, 1 top. Bits 1:0 set the area: 10 is one half and 11 is one quarter. Codes 00 and 01 mean the full array. In mode 5, the window is the selected region: a bottom quarter is 0..Q-1, a top quarter is 3Q..max, a bottom half is 0..2Q-1, a top half is 2Q..max, and full is 0..max, where Q is 2^(ADDR_W-2).
- R7: When `zz_n` rises after a retaining period that counts, `valid_mask_o` becomes the quarters that were kept. Mask bit i stands for the quarter whose two top address bits equal i.
- R8: A low period shorter than `ZZMIN_US` does not count. The mask is left unchanged and no recovery starts, even from mode 6.
- R9: In mode 6, `refresh_en_o` is 0. A counted exit from mode 6 clears the mask and enters mode 7, with busy high for `REC_US` microseconds.
- R10: Every rise of `zz_n` that applies no pending word does two things. It restores the deep power-down and partial-refresh settings to their defaults, which are bit 4 = 1 and a full area. It keeps a reduced-size setting in force, and in that case the reduced window also applies outside sleep.
- R11: With `DIRECT_DPD`=1, every fall of `zz_n` enters mode 6 at once and mode writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte-lane enable, active low |
| ub_n | input | 1 | Upper byte-lane enable, active low |
| zz_n | input | 1 | Sleep strobe, active low |
| addr_lo | input | 5 | Low address bits carrying the mode word |
| busy_o | output | 1 | Power-up or recovery wait in progress |
| mode_o | output | 3 | Current power mode code |
| refresh_en_o | output | 1 | Refresh required |
| win_lo_o | output | ADDR_W | First word of the refresh window |
| win_hi_o | output | ADDR_W | Last word of the refresh window |
| valid_mask_o | output | 4 | Quarters retained through the last counted sleep |

## Verification
The retention logic is exercised with mode words for a top quarter, a bottom half, the reserved area code, a deep power-down request and a reduced-size top half. Comparing the resulting windows and masks separates the half and quarter decodes and the two half selections, and shows how code 01 is handled. Each setting is followed by a sleep period with no write, which separates the one-shot settings from the reduced-size setting that persists. Short and long sleep periods show whether the minimum-time rule is enforced. Writes placed inside and after the programming window, together with strobes applied during both waits and on the direct variant, show which stimuli must be ignored.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    S_PWRUP = 3'd0,
    S_STBY  = 3'd1,
    S_ACTV  = 3'd2,
    S_ARM   = 3'd3,
    S_PROG  = 3'd4,
    S_LPR   = 3'd5,
    S_DPD   = 3'd6,
    S_RECOV = 3'd7
  } lp_state_e;

  // mode word as carried on the low address bits
  typedef struct packed {
    logic       dpd_off;  // 0: deep power-down on next sleep
    logic       rms;      // 1: reduced size, persists across sleep exits
    logic       top;      // 1: upper half of the array
    logic [1:0] area;     // 10 half, 11 quarter, else full
  } lp_mreg_t;

  localparam lp_mreg_t MREG_DEF = '{dpd_off: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};

endpackage

// File: rtl/lp_region_dec.sv
module lp_region_dec #(
  parameter int ADDR_W = 20
) (
  input  logic              use_region,
  input  logic              top,
  input  logic [1:0]        area,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi,
  output logic [3:0]        qmask
);
  localparam logic [ADDR_W-1:0] QTR  = ADDR_W'(1) << (ADDR_W-2);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W-1);
  localparam logic [ADDR_W-1:0] ALL  = '1;

  always_comb begin
    lo    = '0;
    hi    = ALL;
    qmask = 4'b1111;
    if (use_region) begin
      case (area)
        2'b10: begin
          if (top) begin
            lo    = HALF;
            qmask = 4'b1100;
          end else begin
            hi    = HALF - ADDR_W'(1);
            qmask = 4'b0011;
          end
        end
        2'b11: begin
          if (top) begin
            lo    = HALF + QTR;
            qmask = 4'b1000;
          end else begin
            hi    = QTR - ADDR_W'(1);
            qmask = 4'b0001;
          end
        end
        default: ;  // full array, reserved code included
      endcase
    end
  end
endmodule

// File: rtl/lp_mode_store.sv
module lp_mode_store
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cap_en,
  input  lp_mreg_t cap_val,
  input  logic     apply,
  input  logic     revert,
  output lp_mreg_t cur_o
);
  lp_mreg_t pend_q, cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (apply) begin
      cur_d = pend_q;
    end else if (revert) begin
      if (cur_q.rms) cur_d.dpd_off = 1'b1;
      else           cur_d = MREG_DEF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= MREG_DEF;
      cur_q  <= MREG_DEF;
    end else begin
      if (cap_en) pend_q <= cap_val;
      cur_q <= cur_d;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_pkg::*;
#(
  parameter int PWRUP_CYC  = 7500,
  parameter int REC_CYC    = 7500,
  parameter int ZZMIN_CYC  = 500,
  parameter int ZZWE_CYC   = 50,
  parameter int DIRECT_DPD = 0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      zz_n,
  input  logic      acc,
  input  logic      wr_act,
  input  logic      dpd_en,
  output lp_state_e state_o,
  output logic      pwrup_done,
  output logic      lose_par,
  output logic      lose_dpd,
  output logic      apply,
  output logic      revert,
  output logic      cap_en
);
  localparam int M1      = (PWRUP_CYC > REC_CYC) ? PWRUP_CYC : REC_CYC;
  localparam int M2      = (M1 > ZZMIN_CYC) ? M1 : ZZMIN_CYC;
  localparam int CNT_MAX = (M2 > ZZWE_CYC) ? M2 : ZZWE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam bit DIRECT  = (DIRECT_DPD != 0);

  lp_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             long_low, keep_cnt;

  assign long_low = (cnt_q >= CNT_W'(ZZMIN_CYC - 1));

  always_comb begin
    state_d    = state_q;
    pwrup_done = 1'b0;
    lose_par   = 1'b0;
    lose_dpd   = 1'b0;
    apply      = 1'b0;
    revert     = 1'b0;
    case (state_q)
      S_PWRUP: if (cnt_q == CNT_W'(PWRUP_CYC - 1)) begin
        state_d    = S_STBY;
        pwrup_done = 1'b1;
      end
      S_STBY, S_ACTV: begin
        if (!zz_n)    state_d = DIRECT ? S_DPD : S_ARM;
        else if (acc) state_d = S_ACTV;
        else          state_d = S_STBY;
      end
      S_ARM: begin
        if (zz_n) begin
          state_d = S_STBY;
          revert  = 1'b1;
        end else if (wr_act && !DIRECT) begin
          state_d = S_PROG;
        end else if (cnt_q >= CNT_W'(ZZWE_CYC - 1)) begin
          state_d = dpd_en ? S_DPD : S_LPR;
        end
      end
      S_PROG: if (zz_n) begin
        state_d = S_STBY;
        apply   = 1'b1;
      end
      S_LPR: if (zz_n) begin
        state_d  = S_STBY;
        revert   = 1'b1;
        lose_par = long_low;
      end
      S_DPD: if (zz_n) begin
        revert = 1'b1;
        if (long_low) begin
          state_d  = S_RECOV;
          lose_dpd = 1'b1;
        end else begin
          state_d = S_STBY;
        end
      end
      S_RECOV: if (cnt_q == CNT_W'(REC_CYC - 1)) state_d = S_STBY;
      default: state_d = S_PWRUP;
    endcase
  end

  // low time keeps counting across the window close
  assign keep_cnt = (state_q == S_ARM) && (state_d == S_LPR || state_d == S_DPD);
  assign cap_en   = !DIRECT && wr_act && (state_q == S_ARM || state_q == S_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_PWRUP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q && !keep_cnt) cnt_q <= '0;
      else if (cnt_q != CNT_W'(CNT_MAX))   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
  import lp_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int CLK_PER_US = 50,
  parameter int PWRUP_US   = 150,
  parameter int REC_US     = 150,
  parameter int ZZMIN_US   = 10,
  parameter int ZZWE_US    = 1,
  parameter int DIRECT_DPD = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic              zz_n,
  input  logic [4:0]        addr_lo,
  output logic              busy_o,
  output logic [2:0]        mode_o,
  output logic              refresh_en_o,
  output logic [ADDR_W-1:0] win_lo_o,
  output logic [ADDR_W-1:0] win_hi_o,
  output logic [3:0]        valid_mask_o
);
  localparam int PWRUP_CYC = CLK_PER_US * PWRUP_US;
  localparam int REC_CYC   = CLK_PER_US * REC_US;
  localparam int ZZMIN_CYC = CLK_PER_US * ZZMIN_US;
  localparam int ZZWE_CYC  = CLK_PER_US * ZZWE_US;

  lp_state_e         state;
  lp_mreg_t          cur;
  logic              acc, wr_act, dpd_en, use_region;
  logic              pwrup_done, lose_par, lose_dpd, apply, revert, cap_en;
  logic [ADDR_W-1:0] dec_lo, dec_hi;
  logic [3:0]        dec_mask;

  assign acc        = !cs_n && (!lb_n || !ub_n);
  assign wr_act     = acc && !we_n;
  assign dpd_en     = (DIRECT_DPD != 0) || !cur.dpd_off;
  assign use_region = (state == S_LPR) || cur.rms;

  lp_seq #(
    .PWRUP_CYC (PWRUP_CYC),
    .REC_CYC   (REC_CYC),
    .ZZMIN_CYC (ZZMIN_CYC),
    .ZZWE_CYC  (ZZWE_CYC),
    .DIRECT_DPD(DIRECT_DPD)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .zz_n      (zz_n),
    .acc       (acc),
    .wr_act    (wr_act),
    .dpd_en    (dpd_en),
    .state_o   (state),
    .pwrup_done(pwrup_done),
    .lose_par  (lose_par),
    .lose_dpd  (lose_dpd),
    .apply     (apply),
    .revert    (revert),
    .cap_en    (cap_en)
  );

  lp_mode_store u_mreg (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .cap_val(lp_mreg_t'(addr_lo)),
    .apply  (apply),
    .revert (revert),
    .cur_o  (cur)
  );

  lp_region_dec #(.ADDR_W(ADDR_W)) u_region (
    .use_region(use_region),
    .top       (cur.top),
    .area      (cur.area),
    .lo        (dec_lo),
    .hi        (dec_hi),
    .qmask     (dec_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o       <= 1'b1;
      mode_o       <= S_PWRUP;
      refresh_en_o <= 1'b0;
      win_lo_o     <= '0;
      win_hi_o     <= '1;
      valid_mask_o <= 4'b0000;
    end else begin
      busy_o       <= (state == S_PWRUP) || (state == S_RECOV);
      mode_o       <= state;
      refresh_en_o <= (state == S_STBY) || (state == S_ACTV) || (state == S_ARM) ||
                      (state == S_PROG) || (state == S_LPR);
      win_lo_o     <= dec_lo;
      win_hi_o     <= dec_hi;
      if (pwrup_done)    valid_mask_o <= 4'b1111;
      else if (lose_dpd) valid_mask_o <= 4'b0000;
      else if (lose_par) valid_mask_o <= dec_mask;
    end
  end
endmodule

// File: rtl/lp_sleep_ctrl_chk.sv
module lp_sleep_ctrl_chk #(
  parameter int ADDR_W     = 20,
  parameter int DIRECT_DPD = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic [2:0]        mode_o,
  input logic              refresh_en_o,
  input logic [ADDR_W-1:0] win_lo_o,
  input logic [ADDR_W-1:0] win_hi_o,
  input logic [3:0]        valid_mask_o
);
  // R1
  pwrup_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (mode_o == 3'd1));

  // R3
  busy_mode_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (mode_o == 3'd0 || mode_o == 3'd7));

  // R9
  dpd_norefresh_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd6) |-> !refresh_en_o);

  // R9
  recov_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd7 && $past(mode_o) != 3'd7) |-> ($past(mode_o) == 3'd6 && valid_mask_o == 4'b0000));

  // R7
  mask_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(valid_mask_o) |-> (mode_o == 3'd0 || mode_o == 3'd5 || mode_o == 3'd6));

  // R6
  win_order_chk: assert property (@(posedge clk) disable iff (rst)
    win_lo_o <= win_hi_o);

  // R11
  direct_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3 || mode_o == 3'd4 || mode_o == 3'd5) |-> (DIRECT_DPD == 0));
endmodule

bind lp_sleep_ctrl lp_sleep_ctrl_chk #(.ADDR_W(ADDR_W), .DIRECT_DPD(DIRECT_DPD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .mode_o      (mode_o),
  .refresh_en_o(refresh_en_o),
  .win_lo_o    (win_lo_o),
  .win_hi_o    (win_hi_o),
  .valid_mask_o(valid_mask_o)
);

// File: tb/tb_lp_sleep_ctrl.sv
module tb_lp_sleep_ctrl;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1, zz_n = 1'b1, zz_d = 1'b1;
  logic [4:0] addr_lo = '0;

  logic          busy, ref_en, busy_d, ref_d;
  logic [2:0]    mode, mode_d;
  logic [AW-1:0] wlo, whi, wlo_d, whi_d;
  logic [3:0]    mask, mask_d;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lp_sleep_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .zz_n(zz_n), .addr_lo(addr_lo), .busy_o(busy), .mode_o(mode),
    .refresh_en_o(ref_en), .win_lo_o(wlo), .win_hi_o(whi), .valid_mask_o(mask)
  );

  lp_sleep_ctrl #(.DIRECT_DPD(1)) dut_d (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .zz_n(zz_d), .addr_lo(addr_lo), .busy_o(busy_d), .mode_o(mode_d),
    .refresh_en_o(ref_d), .win_lo_o(wlo_d), .win_hi_o(whi_d), .valid_mask_o(mask_d)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_idle;
    cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  task automatic wr_cycle(input logic [4:0] v);
    @(negedge clk);
    addr_lo = v; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0;
    wait_cyc(3);
    set_idle();
  endtask

  // load a mode word inside the window, then apply it
  task automatic prog(input logic [4:0] v, input string tag);
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(3);
    wr_cycle(v);
    wait_cyc(3);
    chk({tag, " R4 mode after write"}, mode, 3'd4);
    zz_n = 1'b1;
    wait_cyc(5);
  endtask

  // sleep for n cycles, checking the mode after the window closes
  task automatic sleep(input int n, input logic [2:0] exp_mode, input string tag);
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    chk({tag, " sleep mode"}, mode, exp_mode);
    wait_cyc(n - 60);
    zz_n = 1'b1;
    wait_cyc(5);
  endtask

  task automatic t_reset;
    wait_cyc(2);
    chk("R1 busy in reset", busy, 1'b1);
    chk("R1 mode in reset", mode, 3'd0);
    chk("R1 refresh in reset", ref_en, 1'b0);
    chk("R1 mask in reset", mask, 4'b0000);
    rst = 1'b0;
  endtask

  task automatic t_powerup;
    wait_cyc(100);
    cs_n = 1'b0; lb_n = 1'b0; zz_n = 1'b0;
    wait_cyc(10);
    chk("R3 mode during power-up", mode, 3'd0);
    chk("R3 busy during power-up", busy, 1'b1);
    zz_n = 1'b1; set_idle();
    wait_cyc(7300);
    chk("R1 still busy near end", busy, 1'b1);
    wait_cyc(200);
    chk("R1 busy after wait", busy, 1'b0);
    chk("R1 standby after wait", mode, 3'd1);
    chk("R1 mask after wait", mask, 4'b1111);
    chk("R1 refresh after wait", ref_en, 1'b1);
    chk("R11 direct busy after wait", busy_d, 1'b0);
  endtask

  task automatic t_active;
    cs_n = 1'b0; lb_n = 1'b0; wait_cyc(3);
    chk("R2 active lower lane", mode, 3'd2);
    lb_n = 1'b1; ub_n = 1'b0; wait_cyc(3);
    chk("R2 active upper lane", mode, 3'd2);
    ub_n = 1'b1; wait_cyc(3);
    chk("R2 standby lanes high", mode, 3'd1);
    cs_n = 1'b1; lb_n = 1'b0; wait_cyc(3);
    chk("R2 standby cs high", mode, 3'd1);
    set_idle(); wait_cyc(2);
  endtask

  task automatic t_default_sleep;
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(3);
    chk("R4 window mode", mode, 3'd3);
    wait_cyc(57);
    chk("R5 retaining sleep", mode, 3'd5);
    chk("R6 default window lo", wlo, 20'h00000);
    chk("R6 default window hi", whi, 20'hFFFFF);
    wait_cyc(540);
    zz_n = 1'b1; wait_cyc(5);
    chk("R7 full mask", mask, 4'b1111);
    chk("R2 back to standby", mode, 3'd1);
  endtask

  task automatic t_quarter_top;
    prog(5'b10111, "qtop");
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    chk("R6 quarter top lo", wlo, 20'hC0000);
    chk("R6 quarter top hi", whi, 20'hFFFFF);
    wait_cyc(540);
    zz_n = 1'b1; wait_cyc(5);
    chk("R7 quarter top mask", mask, 4'b1000);
    chk("R10 window full after revert", whi - wlo, 20'hFFFFF);
    sleep(600, 3'd5, "R10 reverted");
    chk("R10 mask full after reverted period", mask, 4'b1111);
  endtask

  task automatic t_half_bottom;
    prog(5'b10010, "hbot");
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    chk("R6 half bottom lo", wlo, 20'h00000);
    chk("R6 half bottom hi", whi, 20'h7FFFF);
    wait_cyc(540);
    zz_n = 1'b1; wait_cyc(5);
    chk("R7 half bottom mask", mask, 4'b0011);
  endtask

  task automatic t_reserved;
    prog(5'b10001, "rsvd");
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    chk("R6 reserved code hi", whi, 20'hFFFFF);
    wait_cyc(540);
    zz_n = 1'b1; wait_cyc(5);
    chk("R6 reserved code mask", mask, 4'b1111);
  endtask

  task automatic t_short;
    prog(5'b10011, "qbot");
    sleep(100, 3'd5, "R8 short retain");
    chk("R8 mask kept after short period", mask, 4'b1111);
    prog(5'b00000, "dpd short");
    sleep(100, 3'd6, "R8 short dpd");
    chk("R8 no recovery after short dpd", mode, 3'd1);
    chk("R8 not busy after short dpd", busy, 1'b0);
    chk("R8 mask kept after short dpd", mask, 4'b1111);
  endtask

  task automatic t_late_write;
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    wr_cycle(5'b00000);
    wait_cyc(2);
    chk("R5 late write ignored", mode, 3'd5);
    wait_cyc(530);
    zz_n = 1'b1; wait_cyc(5);
    sleep(600, 3'd5, "R5 late word not applied");
  endtask

  task automatic t_dpd;
    prog(5'b00000, "dpd");
    @(negedge clk); zz_n = 1'b0;
    wait_cyc(60);
    chk("R5 dpd entered", mode, 3'd6);
    chk("R9 no refresh in dpd", ref_en, 1'b0);
    wait_cyc(540);
    zz_n = 1'b1; wait_cyc(5);
    chk("R9 recovery mode", mode, 3'd7);
    chk("R9 busy in recovery", busy, 1'b1);
    chk("R9 mask cleared", mask, 4'b0000);
    cs_n = 1'b0; lb_n = 1'b0; zz_n = 1'b0;
    wait_cyc(10);
    chk("R3 strobes ignored in recovery", mode, 3'd7);
    set_idle(); zz_n = 1'b1;
    wait_cyc(6985);
    chk("R9 still busy before end", busy, 1'b1);
    wait_cyc(600);
    chk("R9 busy released", busy, 1'b0);
    chk("R9 standby after recovery", mode, 3'd1);
    sleep(600, 3'd5, "R10 dpd reverted");
    chk("R7 mask restored by full period", mask, 4'b1111);
  endtask

  task automatic t_rms;
    prog(5'b11110, "rms");
    chk("R10 reduced window lo in standby", wlo, 20'h80000);
    chk("R10 reduced window hi in standby", whi, 20'hFFFFF);
    sleep(600, 3'd5, "R10 rms sleep");
    chk("R10 rms mask", mask, 4'b1100);
    chk("R10 rms persists lo", wlo, 20'h80000);
    sleep(600, 3'd5, "R10 rms again");
    chk("R10 rms persists after second exit", wlo, 20'h80000);
    prog(5'b10000, "rms off");
    chk("R10 full window after rewrite", wlo, 20'h00000);
  endtask

  task automatic t_direct;
    @(negedge clk); zz_d = 1'b0;
    wait_cyc(3);
    chk("R11 direct dpd at once", mode_d, 3'd6);
    chk("R11 direct no refresh", ref_d, 1'b0);
    wr_cycle(5'b10111);
    wait_cyc(2);
    chk("R11 direct write ignored", mode_d, 3'd6);
    wait_cyc(600);
    zz_d = 1'b1; wait_cyc(5);
    chk("R11 direct recovery", mode_d, 3'd7);
    chk("R11 direct mask cleared", mask_d, 4'b0000);
    chk("R11 direct window full", whi_d - wlo_d, 20'hFFFFF);
    wait_cyc(7600);
    chk("R11 direct standby", mode_d, 3'd1);
    chk("R11 direct busy low", busy_d, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_powerup();
    t_active();
    t_default_sleep();
    t_quarter_top();
    t_half_bottom();
    t_reserved();
    t_short();
    t_late_write();
    t_dpd();
    t_rms();
    t_direct();
    report();
  end
endmodule